// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block holds the command register that lets a small processor rewrite its own program flash, and it sequences the commands written there. Software first writes a five-bit command code. An accepted code arms the controller for a short window. A store strobe that arrives inside that window carries a 16-bit pointer and a 16-bit data word, and it runs the armed command. A fill command loads one word into a temporary page buffer. The other four commands (page erase, page write, lock-bit set and section re-enable) go to the flash array through a request/done handshake.

The pointer has two fields. Bit 0 is a byte select, and this block ignores it. The bits above it select a word inside the page. The remaining high bits select the page. When an operation starts, the block latches the page number and the operation type, so software is free to change the pointer afterwards. An erase or a write that targets a page at or above a boundary page (the section that cannot be read while it is written) raises a CPU-halt output until the flash reports completion. The flash side reads the page buffer through its own synchronous read port.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: After reset, cfg_rdata reads 0, and fl_req and cpu_halt are low.
- R2: A register write is accepted only for the codes 5'b00001 (fill), 5'b00011 (erase), 5'b00101 (write), 5'b01001 (lock set) and 5'b10001 (section re-enable). Any other code leaves cfg_rdata unchanged.
- R3: After an accepted write on clock edge E0, cfg_rdata shows the code after E0, E1, E2 and E3, and reads 0 after E4 if no strobe is taken. A strobe sampled at E1 through E4 is taken. A strobe sampled at E5 or later is ignored.
- R4: A strobe taken under the fill code writes st_data into buffer word st_ptr[5:1], whatever st_ptr[0] is. cfg_rdata reads 0 from the next cycle.
- R5: A strobe taken under erase or write raises fl_req on the same edge. fl_op is 0 for erase and 1 for write, fl_page is st_ptr[15:6] and fl_data is 0. fl_req stays high until fl_done is sampled high.
- R6: While fl_req is high, fl_page and fl_op hold their latched values even when st_ptr changes.
- R7: While an operation is pending, cfg_rdata keeps the command code with bit 0 set. On the edge that samples fl_done, cfg_rdata, fl_req and cpu_halt all go to 0.
- R8: A lock-set strobe issues fl_op 2 with fl_page 0 and fl_data equal to st_data. A re-enable strobe issues fl_op 3 with fl_page 0 and fl_data 0. In both cases the pointer has no effect.
- R9: cpu_halt is high for the whole of an erase or write whose page is at or above NRWW_FIRST_PAGE. It stays low for lower pages and for lock-set and re-enable.
- R10: While fl_req is high, register writes and store strobes change neither cfg_rdata nor the page buffer, and they start no new operation.
- R11: fl_buf_rdata returns the buffer word at fl_buf_addr one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Command register write strobe |
| cfg_wdata | input | 5 | Command code to write |
| cfg_rdata | output | 5 | Current command register contents |
| st_valid | input | 1 | Store instruction strobe |
| st_ptr | input | 16 | Store pointer (page, word, byte fields) |
| st_data | input | 16 | Store data word |
| fl_req | output | 1 | Flash operation request, held until done |
| fl_op | output | 2 | Operation: 0 erase, 1 write, 2 lock set, 3 re-enable |
| fl_page | output | 10 | Latched page number |
| fl_data | output | 16 | Lock-bit data for the lock-set operation |
| fl_done | input | 1 | Completion pulse from the flash array |
| fl_buf_addr | input | 5 | Page buffer read address from the flash side |
| fl_buf_rdata | output | 16 | Page buffer read data, one cycle latency |
| cpu_halt | output | 1 | Processor stall during an erase or write of the upper section |

## Verification
An arm counter that is off by one shows up at cfg_rdata within five cycles of a register write. It also shows up as a fill that lands when it should not, or goes missing when it should land, and the buffer read port exposes that on the next read. A latch that follows the live pointer shows as fl_page moving on the first busy cycle after st_ptr changes. A decode or halt-compare fault appears at fl_op, fl_data or cpu_halt on the very edge where the operation starts. A broken guard against activity while busy corrupts cfg_rdata or a buffer word that the bench reads back right after the operation completes.

// File: rtl/flash_sp_pkg.sv
package flash_sp_pkg;

  localparam int CMD_W = 5;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_FILL,
    CMD_ERASE,
    CMD_WRITE,
    CMD_LOCK,
    CMD_RWW
  } cmd_kind_e;

  typedef enum logic [1:0] {
    FOP_ERASE = 2'd0,
    FOP_WRITE = 2'd1,
    FOP_LOCK  = 2'd2,
    FOP_RWW   = 2'd3
  } flash_op_e;

  // Map a raw command code to its kind; unlisted codes are not commands.
  function automatic cmd_kind_e decode_cmd(input logic [CMD_W-1:0] code);
    case (code)
      5'b00001: decode_cmd = CMD_FILL;
      5'b00011: decode_cmd = CMD_ERASE;
      5'b00101: decode_cmd = CMD_WRITE;
      5'b01001: decode_cmd = CMD_LOCK;
      5'b10001: decode_cmd = CMD_RWW;
      default:  decode_cmd = CMD_NONE;
    endcase
  endfunction

  function automatic flash_op_e kind_to_op(input cmd_kind_e kind);
    case (kind)
      CMD_WRITE: kind_to_op = FOP_WRITE;
      CMD_LOCK:  kind_to_op = FOP_LOCK;
      CMD_RWW:   kind_to_op = FOP_RWW;
      default:   kind_to_op = FOP_ERASE;
    endcase
  endfunction

endpackage

// File: rtl/fsp_cmd_reg.sv
// Command register with its arm window and auto-clear.
module fsp_cmd_reg
  import flash_sp_pkg::*;
#(
  parameter int ARM_CYCLES = 4,
  localparam int CNT_W = $clog2(ARM_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CMD_W-1:0] cfg_wdata,
  input  logic             st_valid,
  input  logic             op_busy,
  input  logic             op_done,
  output logic [CMD_W-1:0] cmd_q,
  output cmd_kind_e        kind,
  output logic             st_accept
);

  logic [CNT_W-1:0] cnt_q;
  logic             load;
  logic             armed;

  assign load      = cfg_we && (decode_cmd(cfg_wdata) != CMD_NONE);
  assign armed     = (cnt_q != '0);
  assign kind      = decode_cmd(cmd_q);
  // A register write in the same cycle re-arms and wins over the strobe.
  assign st_accept = st_valid && armed && !op_busy && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      cnt_q <= '0;
    end else if (op_busy) begin
      cnt_q <= '0;
      if (op_done) cmd_q <= '0;
    end else if (load) begin
      cmd_q <= cfg_wdata;
      cnt_q <= CNT_W'(ARM_CYCLES);
    end else if (armed) begin
      if (st_accept) begin
        cnt_q <= '0;
        // Flash commands keep the code until completion.
        if (kind == CMD_FILL) cmd_q <= '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) cmd_q <= '0;
      end
    end
  end

endmodule

// File: rtl/fsp_page_buf.sv
// Temporary page buffer: one write port, one registered read port.
module fsp_page_buf #(
  parameter int WORDS  = 32,
  parameter int DATA_W = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/fsp_op_seq.sv
// Flash operation sequencer: latches the operands, holds the request until done.
module fsp_op_seq
  import flash_sp_pkg::*;
#(
  parameter int PAGE_W          = 10,
  parameter int DATA_W          = 16,
  parameter int NRWW_FIRST_PAGE = 896
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  cmd_kind_e         start_kind,
  input  logic [PAGE_W-1:0] start_page,
  input  logic [DATA_W-1:0] start_data,
  input  logic              fl_done,
  output logic              busy,
  output logic              op_done,
  output logic [1:0]        fl_op,
  output logic [PAGE_W-1:0] fl_page,
  output logic [DATA_W-1:0] fl_data,
  output logic              cpu_halt
);

  logic paged;

  assign paged   = (start_kind == CMD_ERASE) || (start_kind == CMD_WRITE);
  assign op_done = busy && fl_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      fl_op    <= '0;
      fl_page  <= '0;
      fl_data  <= '0;
      cpu_halt <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        fl_op    <= kind_to_op(start_kind);
        fl_page  <= paged ? start_page : '0;
        fl_data  <= (start_kind == CMD_LOCK) ? start_data : '0;
        cpu_halt <= paged && (start_page >= PAGE_W'(NRWW_FIRST_PAGE));
      end
    end else if (fl_done) begin
      busy     <= 1'b0;
      cpu_halt <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
  import flash_sp_pkg::*;
#(
  parameter int PAGE_WORDS      = 32,
  parameter int PTR_W           = 16,
  parameter int DATA_W          = 16,
  parameter int ARM_CYCLES      = 4,
  parameter int NRWW_FIRST_PAGE = 896,
  localparam int WORD_BITS = $clog2(PAGE_WORDS),
  localparam int PAGE_W    = PTR_W - 1 - WORD_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [CMD_W-1:0]     cfg_wdata,
  output logic [CMD_W-1:0]     cfg_rdata,
  input  logic                 st_valid,
  input  logic [PTR_W-1:0]     st_ptr,
  input  logic [DATA_W-1:0]    st_data,
  output logic                 fl_req,
  output logic [1:0]           fl_op,
  output logic [PAGE_W-1:0]    fl_page,
  output logic [DATA_W-1:0]    fl_data,
  input  logic                 fl_done,
  input  logic [WORD_BITS-1:0] fl_buf_addr,
  output logic [DATA_W-1:0]    fl_buf_rdata,
  output logic                 cpu_halt
);

  cmd_kind_e            kind;
  logic                 st_accept;
  logic                 busy;
  logic                 op_done;
  logic                 fill_we;
  logic                 op_start;
  logic [WORD_BITS-1:0] ptr_word;
  logic [PAGE_W-1:0]    ptr_page;
  logic                 unused_byte_sel;

  assign ptr_word        = st_ptr[WORD_BITS:1];
  assign ptr_page        = st_ptr[PTR_W-1:WORD_BITS+1];
  assign unused_byte_sel = st_ptr[0];

  assign fill_we  = st_accept && (kind == CMD_FILL);
  assign op_start = st_accept && (kind != CMD_FILL);
  assign fl_req   = busy;

  fsp_cmd_reg #(
    .ARM_CYCLES(ARM_CYCLES)
  ) u_cmd (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .st_valid  (st_valid),
    .op_busy   (busy),
    .op_done   (op_done),
    .cmd_q     (cfg_rdata),
    .kind      (kind),
    .st_accept (st_accept)
  );

  fsp_page_buf #(
    .WORDS (PAGE_WORDS),
    .DATA_W(DATA_W)
  ) u_buf (
    .clk    (clk),
    .wr_en  (fill_we),
    .wr_addr(ptr_word),
    .wr_data(st_data),
    .rd_addr(fl_buf_addr),
    .rd_data(fl_buf_rdata)
  );

  fsp_op_seq #(
    .PAGE_W         (PAGE_W),
    .DATA_W         (DATA_W),
    .NRWW_FIRST_PAGE(NRWW_FIRST_PAGE)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (op_start),
    .start_kind(kind),
    .start_page(ptr_page),
    .start_data(st_data),
    .fl_done   (fl_done),
    .busy      (busy),
    .op_done   (op_done),
    .fl_op     (fl_op),
    .fl_page   (fl_page),
    .fl_data   (fl_data),
    .cpu_halt  (cpu_halt)
  );

endmodule

// File: rtl/flash_selfprog_ctrl_chk.sv
module flash_selfprog_ctrl_chk
  import flash_sp_pkg::*;
#(
  parameter int PAGE_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [CMD_W-1:0]  cfg_wdata,
  input logic [CMD_W-1:0]  cfg_rdata,
  input logic              fl_req,
  input logic [1:0]        fl_op,
  input logic [PAGE_W-1:0] fl_page,
  input logic              fl_done,
  input logic              cpu_halt
);

  logic bad_code;
  assign bad_code = (decode_cmd(cfg_wdata) == CMD_NONE);

  a_r2_bad_code_rejected: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && bad_code && !fl_req && cfg_rdata == '0) |=> (cfg_rdata == '0));

  a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
    (fl_req && !fl_done) |=> fl_req);

  a_r6_operands_latched: assert property (@(posedge clk) disable iff (rst)
    (fl_req && !fl_done) |=> ($stable(fl_page) && $stable(fl_op)));

  a_r7_enable_while_busy: assert property (@(posedge clk) disable iff (rst)
    fl_req |-> cfg_rdata[0]);

  a_r7_clear_on_done: assert property (@(posedge clk) disable iff (rst)
    (fl_req && fl_done) |=> (cfg_rdata == '0 && !fl_req && !cpu_halt));

  a_r8_no_page_for_lock_rww: assert property (@(posedge clk) disable iff (rst)
    (fl_req && fl_op[1]) |-> (fl_page == '0));

  a_r9_halt_inside_op: assert property (@(posedge clk) disable iff (rst)
    cpu_halt |-> (fl_req && !fl_op[1]));

  a_r10_reg_frozen_busy: assert property (@(posedge clk) disable iff (rst)
    (fl_req && !fl_done) |=> $stable(cfg_rdata));

endmodule

bind flash_selfprog_ctrl flash_selfprog_ctrl_chk #(
  .PAGE_W(PAGE_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata),
  .fl_req   (fl_req),
  .fl_op    (fl_op),
  .fl_page  (fl_page),
  .fl_done  (fl_done),
  .cpu_halt (cpu_halt)
);

// File: tb/flash_selfprog_ctrl_bench.sv
module flash_selfprog_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BOUNDARY   = 896;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_wdata = '0;
  logic [4:0]  cfg_rdata;
  logic        st_valid = 1'b0;
  logic [15:0] st_ptr = '0;
  logic [15:0] st_data = '0;
  logic        fl_req;
  logic [1:0]  fl_op;
  logic [9:0]  fl_page;
  logic [15:0] fl_data;
  logic        fl_done = 1'b0;
  logic [4:0]  fl_buf_addr = '0;
  logic [15:0] fl_buf_rdata;
  logic        cpu_halt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_selfprog_ctrl #(
    .PAGE_WORDS(32), .PTR_W(16), .DATA_W(16), .ARM_CYCLES(4),
    .NRWW_FIRST_PAGE(BOUNDARY)
  ) u_flash_selfprog_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .st_valid(st_valid), .st_ptr(st_ptr),
    .st_data(st_data), .fl_req(fl_req), .fl_op(fl_op), .fl_page(fl_page),
    .fl_data(fl_data), .fl_done(fl_done), .fl_buf_addr(fl_buf_addr),
    .fl_buf_rdata(fl_buf_rdata), .cpu_halt(cpu_halt)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit code_ok(input int c);
    return (c == 1) || (c == 3) || (c == 5) || (c == 9) || (c == 17);
  endfunction

  function automatic logic [15:0] fill_val(input int w);
    return 16'((w * 257) ^ 16'h3C00);
  endfunction

  task automatic wr_cmd(input logic [4:0] c);
    cfg_we = 1'b1; cfg_wdata = c;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic strobe(input logic [15:0] p, input logic [15:0] d);
    st_valid = 1'b1; st_ptr = p; st_data = d;
    tick();
    st_valid = 1'b0;
  endtask

  task automatic read_buf(input int w, output logic [15:0] v);
    fl_buf_addr = 5'(w);
    tick();
    v = fl_buf_rdata;
  endtask

  task automatic run_op(input logic [4:0] code, input logic [9:0] page,
                        input logic [15:0] data, input logic [1:0] eop,
                        input logic [9:0] epage, input logic [15:0] edata,
                        input bit ehalt, input string req);
    wr_cmd(code);
    tick();
    strobe({page, 5'd7, 1'b1}, data);
    check(fl_req == 1'b1, {req, " R5 req"}, 32'(fl_req), 1);
    check(fl_op == eop, {req, " op"}, 32'(fl_op), 32'(eop));
    check(fl_page == epage, {req, " page"}, 32'(fl_page), 32'(epage));
    check(fl_data == edata, {req, " data"}, 32'(fl_data), 32'(edata));
    check(cpu_halt == ehalt, {req, " R9 halt"}, 32'(cpu_halt), 32'(ehalt));
    // Interference while busy: pointer moves, fill command and strobe (R6, R10).
    cfg_we = 1'b1; cfg_wdata = 5'b00001;
    st_valid = 1'b1; st_ptr = {~page, 5'd2, 1'b0}; st_data = 16'hDEAD;
    for (int k = 0; k < 3; k++) begin
      tick();
      check(fl_page == epage, "R6 page latched", 32'(fl_page), 32'(epage));
      check(cfg_rdata == code, "R10 R7 reg held", 32'(cfg_rdata), 32'(code));
      check(cpu_halt == ehalt, "R9 halt held", 32'(cpu_halt), 32'(ehalt));
    end
    cfg_we = 1'b0; st_valid = 1'b0;
    fl_done = 1'b1;
    tick();
    fl_done = 1'b0;
    check(fl_req == 1'b0, "R7 req cleared", 32'(fl_req), 0);
    check(cfg_rdata == 5'd0, "R7 reg cleared", 32'(cfg_rdata), 0);
    check(cpu_halt == 1'b0, "R7 halt cleared", 32'(cpu_halt), 0);
    tick();
    check(fl_req == 1'b0, "R10 no new op", 32'(fl_req), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check(cfg_rdata == 5'd0, "R1 reg", 32'(cfg_rdata), 0);
    check(fl_req == 1'b0, "R1 req", 32'(fl_req), 0);
    check(cpu_halt == 1'b0, "R1 halt", 32'(cpu_halt), 0);

    // R2 / R3: every code, with window expiry for the accepted ones
    for (int c = 0; c < 32; c++) begin
      logic [4:0] exp;
      exp = code_ok(c) ? 5'(c) : 5'd0;
      wr_cmd(5'(c));
      check(cfg_rdata == exp, "R2 code accept", 32'(cfg_rdata), 32'(exp));
      for (int k = 1; k < 4; k++) begin
        tick();
        check(cfg_rdata == exp, "R3 window open", 32'(cfg_rdata), 32'(exp));
      end
      tick();
      check(cfg_rdata == 5'd0, "R3 window expired", 32'(cfg_rdata), 0);
    end

    // R4: fill every word, byte select toggling, page field arbitrary
    for (int w = 0; w < 32; w++) begin
      wr_cmd(5'b00001);
      strobe({10'((w * 37) % 1024), 5'(w), 1'(w)}, fill_val(w));
      check(cfg_rdata == 5'd0, "R4 fill clears reg", 32'(cfg_rdata), 0);
    end
    for (int w = 0; w < 32; w++) begin
      read_buf(w, v);
      check(v == fill_val(w), "R4 R11 buffer word", 32'(v), 32'(fill_val(w)));
    end

    // R3: strobe delay 1..5 edges after the write edge
    for (int d = 1; d <= 5; d++) begin
      logic [15:0] exp;
      wr_cmd(5'b00001);
      repeat (d - 1) tick();
      strobe({10'd3, 5'(d + 10), 1'b0}, 16'hA000 + 16'(d));
      repeat (5) tick();
      read_buf(d + 10, v);
      exp = (d <= 4) ? 16'hA000 + 16'(d) : fill_val(d + 10);
      check(v == exp, "R3 strobe window", 32'(v), 32'(exp));
    end

    // Flash operations (R5..R10)
    run_op(5'b00011, 10'd5,            16'h1234, 2'd0, 10'd5,            16'h0000, 1'b0, "R5 erase low");
    run_op(5'b00101, 10'(BOUNDARY-1),  16'h5678, 2'd1, 10'(BOUNDARY-1),  16'h0000, 1'b0, "R5 write below");
    run_op(5'b00101, 10'(BOUNDARY),    16'h9ABC, 2'd1, 10'(BOUNDARY),    16'h0000, 1'b1, "R9 write boundary");
    run_op(5'b00011, 10'd1023,         16'h0F0F, 2'd0, 10'd1023,         16'h0000, 1'b1, "R9 erase top");
    run_op(5'b01001, 10'd700,          16'h00C3, 2'd2, 10'd0,            16'h00C3, 1'b0, "R8 lock");
    run_op(5'b10001, 10'd999,          16'h4444, 2'd3, 10'd0,            16'h0000, 1'b0, "R8 rww");

    // R10: the fill strobe offered while busy must not have landed
    read_buf(2, v);
    check(v == fill_val(2), "R10 buffer untouched", 32'(v), 32'(fill_val(2)));

    finish_run();
  end

endmodule